// File: doc/BRIEF.md
# Channel Connection and Stuck-Bus Timeout Controller

This block is the digital control core of a four-channel two-wire bus switch. A host write delivers a set of channel-select bits. The controller closes the switch for each requested channel, but only if that channel's SDA and SCL lines were both idle-high when the write arrived. An override bit lifts that restriction. If a requested channel is low while the override is off, the controller records a failed connection and raises an alert request.

The controller also watches two low-detect flags for the shared internal SDA and SCL nodes. Both flags are asynchronous, so each passes through a two-flop synchronizer. While either node is low, a timer built from a cycle prescaler and a tick counter runs. If the timer reaches the limit chosen by a 2-bit select, the upstream-downstream buffers are disabled and a latched timeout is set. The switch bits keep their values. When both nodes go high again, the timer resets. A single-cycle clear pulse from the register interface clears the latched flags.

Top module: `chan_link_ctrl`

## Requirements
- R1: After reset, the outputs take these values: `sw_on`=0, `ready`=0, `fail_n`=1, `lat_timeout`=0, `rt_timeout`=0 and `alert_req`=0.
- R2: A `sel_wr` pulse with `override`=0 loads `sw_on` with `sel_data & idle_hi`, where bit i is channel i. The new value is visible one clock after the pulse.
- R3: A `sel_wr` pulse with `override`=1 loads `sw_on` with `sel_data` whatever the value of `idle_hi`, and it leaves `fail_n` unchanged.
- R4: A `sel_wr` pulse with `override`=0 drives `fail_n` to 0 when any requested channel has `idle_hi`=0. A write in which every requested channel is high leaves `fail_n` at 1.
- R5: `ready` is 1 exactly when `sw_on` is nonzero and `rt_timeout` is 0.
- R6: The timeout select `tsel` works as follows. 00 disables the timer. 01 gives T_LONG ticks, 10 gives T_LONG/2 ticks and 11 gives T_LONG/4 ticks. One tick is TICK_DIV clocks. Count k=1 as the first clock edge at which a raw low flag is sampled. While a flag stays low, `rt_timeout` becomes 1 after edge 2+L*TICK_DIV, where L is the selected tick count.
- R7: When both synchronized flags are high, the timer restarts from zero, and `rt_timeout` falls two edges after the raw flags release.
- R8: While `rt_timeout` is 1, `ready` is 0 and `sw_on` keeps its value. `ready` returns when the stuck node recovers.
- R9: `lat_timeout` sets one clock after `rt_timeout` and stays set until `clr_pulse`. `clr_pulse` also sets `fail_n` back to 1.
- R10: `alert_req` equals `lat_timeout | ~fail_n`. A `clr_pulse` that arrives while `rt_timeout` is 1 leaves `lat_timeout` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel_wr | input | 1 | Single-cycle pulse: write the channel-select bits |
| sel_data | input | NCH | Requested channels |
| override | input | 1 | When 1, connect regardless of channel idle state |
| idle_hi | input | NCH | Per-channel flag: SDA and SCL both high |
| tsel | input | 2 | Timeout select |
| sda_low_raw | input | 1 | Asynchronous low flag for the internal SDA node |
| scl_low_raw | input | 1 | Asynchronous low flag for the internal SCL node |
| clr_pulse | input | 1 | Single-cycle clear of the latched flags |
| sw_on | output | NCH | Switch enables for each channel |
| buf_en | output | 1 | Enable for the upstream-downstream buffers |
| ready | output | 1 | 1 while connected upstream; also serves as status bit 7 |
| rt_timeout | output | 1 | Real-time timeout status |
| lat_timeout | output | 1 | Latched timeout status |
| fail_n | output | 1 | Failed connection status, active low |
| alert_req | output | 1 | Alert request |

## Verification
The bench builds the controller with TICK_DIV=4 and T_LONG=8, so the three timeout limits are 32, 16 and 8 clocks. At these sizes the bench can check every select code at its exact expiry edge and also one edge earlier. The short windows also leave room to check a timer restart partway through a count, recovery of a stuck node, and a clear that arrives while the timeout is still active.

// File: rtl/chan_link_ctrl.sv
module chan_link_ctrl #(
  parameter int NCH      = 4,
  parameter int TICK_DIV = 1000,
  parameter int T_LONG   = 30
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel_wr,
  input  logic [NCH-1:0] sel_data,
  input  logic           override,
  input  logic [NCH-1:0] idle_hi,
  input  logic [1:0]     tsel,
  input  logic           sda_low_raw,
  input  logic           scl_low_raw,
  input  logic           clr_pulse,
  output logic [NCH-1:0] sw_on,
  output logic           buf_en,
  output logic           ready,
  output logic           rt_timeout,
  output logic           lat_timeout,
  output logic           fail_n,
  output logic           alert_req
);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam int TW = $clog2(T_LONG + 1);
  localparam logic [PW-1:0] PRE_TOP = PW'(TICK_DIV - 1);

  logic [1:0]    sda_sync, scl_sync;
  logic          any_low;
  logic [PW-1:0] pre_cnt;
  logic [TW-1:0] ticks, limit;
  logic          bad_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sda_sync <= '0;
      scl_sync <= '0;
    end else begin
      sda_sync <= {sda_sync[0], sda_low_raw};
      scl_sync <= {scl_sync[0], scl_low_raw};
    end

  assign any_low = sda_sync[1] | scl_sync[1];

  always_comb
    case (tsel)
      2'b10:   limit = TW'(T_LONG / 2);
      2'b11:   limit = TW'(T_LONG / 4);
      default: limit = TW'(T_LONG);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_cnt <= '0;
      ticks   <= '0;
    end else if (!any_low) begin
      pre_cnt <= '0;
      ticks   <= '0;
    end else if (pre_cnt == PRE_TOP) begin
      pre_cnt <= '0;
      if (ticks < limit) ticks <= ticks + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end

  assign rt_timeout = (tsel != 2'b00) && any_low && (ticks >= limit);

  assign bad_req = |(sel_data & ~idle_hi);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sw_on <= '0;
    else if (sel_wr) sw_on <= override ? sel_data : (sel_data & idle_hi);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fail_n <= 1'b1;
    else if (sel_wr && !override && bad_req) fail_n <= 1'b0;
    else if (clr_pulse) fail_n <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lat_timeout <= 1'b0;
    else if (rt_timeout) lat_timeout <= 1'b1;
    else if (clr_pulse) lat_timeout <= 1'b0;

  assign buf_en    = (|sw_on) && !rt_timeout;
  assign ready     = buf_en;
  assign alert_req = lat_timeout | ~fail_n;

  // R5
  ready_needs_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (sw_on != '0));

  // R8
  timeout_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_timeout |-> !ready);

  // R8
  switch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> $stable(sw_on));

  // R9
  latch_follows_rt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_timeout |=> lat_timeout);

  // R3
  override_no_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && override && !clr_pulse) |=> $stable(fail_n));

  // R6
  disabled_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tsel == 2'b00) |-> !rt_timeout);
endmodule

// File: tb/chan_link_ctrl_test.sv
module chan_link_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DIV = 4;
  localparam int TL  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_wr = 1'b0, override = 1'b0, clr_pulse = 1'b0;
  logic sda_low_raw = 1'b0, scl_low_raw = 1'b0;
  logic [NCH-1:0] sel_data = '0, idle_hi = '1;
  logic [1:0] tsel = 2'b00;
  logic [NCH-1:0] sw_on;
  logic buf_en, ready, rt_timeout, lat_timeout, fail_n, alert_req;

  int n_chk = 0;
  int n_bad = 0;

  chan_link_ctrl #(.NCH(NCH), .TICK_DIV(DIV), .T_LONG(TL)) uut (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_data(sel_data),
    .override(override), .idle_hi(idle_hi), .tsel(tsel),
    .sda_low_raw(sda_low_raw), .scl_low_raw(scl_low_raw),
    .clr_pulse(clr_pulse), .sw_on(sw_on), .buf_en(buf_en), .ready(ready),
    .rt_timeout(rt_timeout), .lat_timeout(lat_timeout), .fail_n(fail_n),
    .alert_req(alert_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_sel(input logic [NCH-1:0] s, input logic ov);
    sel_data = s; override = ov; sel_wr = 1'b1;
    edges(1);
    sel_wr = 1'b0;
  endtask

  task automatic clear_flags();
    clr_pulse = 1'b1;
    edges(1);
    clr_pulse = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 sw_on", 8'(sw_on), 8'h0);
    chk("R1 ready", 8'(ready), 8'h0);
    chk("R1 fail_n", 8'(fail_n), 8'h1);
    chk("R1 lat", 8'(lat_timeout), 8'h0);
    chk("R1 rt", 8'(rt_timeout), 8'h0);
    chk("R1 alert", 8'(alert_req), 8'h0);
  endtask

  task automatic t_gated();
    idle_hi = 4'b1011;
    write_sel(4'b0111, 1'b0);
    chk("R2 gated sw_on", 8'(sw_on), 8'h03);
    chk("R4 fail_n low", 8'(fail_n), 8'h0);
    chk("R10 alert on fail", 8'(alert_req), 8'h1);
    chk("R5 ready", 8'(ready), 8'h1);
    clear_flags();
    chk("R9 clr fail_n", 8'(fail_n), 8'h1);
    chk("R10 alert clear", 8'(alert_req), 8'h0);
    idle_hi = 4'b1111;
    write_sel(4'b0101, 1'b0);
    chk("R2 all high sw_on", 8'(sw_on), 8'h05);
    chk("R4 no fail", 8'(fail_n), 8'h1);
    write_sel(4'b0000, 1'b0);
    chk("R5 none ready", 8'(ready), 8'h0);
  endtask

  task automatic t_override();
    idle_hi = 4'b0000;
    write_sel(4'b1100, 1'b1);
    chk("R3 sw_on", 8'(sw_on), 8'h0c);
    chk("R3 fail_n", 8'(fail_n), 8'h1);
    chk("R5 ready", 8'(ready), 8'h1);
    idle_hi = 4'b1111;
  endtask

  task automatic t_timeout(input logic [1:0] code, input int lt);
    write_sel(4'b0001, 1'b1);
    tsel = code;
    sda_low_raw = 1'b1;
    edges(1 + lt*DIV);
    chk("R6 before expiry", 8'(rt_timeout), 8'h0);
    edges(1);
    chk("R6 at expiry", 8'(rt_timeout), 8'h1);
    chk("R8 ready off", 8'(ready), 8'h0);
    chk("R8 sw_on kept", 8'(sw_on), 8'h01);
    edges(1);
    chk("R9 lat set", 8'(lat_timeout), 8'h1);
    sda_low_raw = 1'b0;
    edges(1);
    chk("R7 rt still on", 8'(rt_timeout), 8'h1);
    edges(1);
    chk("R7 rt off", 8'(rt_timeout), 8'h0);
    chk("R8 ready back", 8'(ready), 8'h1);
    chk("R9 lat held", 8'(lat_timeout), 8'h1);
    chk("R10 alert lat", 8'(alert_req), 8'h1);
    clear_flags();
    chk("R9 lat cleared", 8'(lat_timeout), 8'h0);
    edges(2);
  endtask

  task automatic t_restart();
    tsel = 2'b11;
    scl_low_raw = 1'b1;
    edges(2*DIV);
    scl_low_raw = 1'b0;
    edges(3);
    scl_low_raw = 1'b1;
    edges(1 + 2*DIV);
    chk("R7 restarted count", 8'(rt_timeout), 8'h0);
    edges(1);
    chk("R7 full count", 8'(rt_timeout), 8'h1);
    clear_flags();
    chk("R10 clr during rt", 8'(lat_timeout), 8'h1);
    scl_low_raw = 1'b0;
    edges(3);
    clear_flags();
    chk("R9 clr after", 8'(lat_timeout), 8'h0);
  endtask

  task automatic t_disabled();
    tsel = 2'b00;
    sda_low_raw = 1'b1;
    edges(3*TL*DIV);
    chk("R6 disabled", 8'(rt_timeout), 8'h0);
    chk("R6 disabled lat", 8'(lat_timeout), 8'h0);
    sda_low_raw = 1'b0;
    edges(3);
  endtask

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(1);
    t_reset();
    t_gated();
    t_override();
    t_timeout(2'b01, TL);
    t_timeout(2'b10, TL/2);
    t_timeout(2'b11, TL/4);
    t_restart();
    t_disabled();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule